// File: doc/BRIEF.md
# Masked Register-Write Command Parser

This block sits between a command fetcher and a blit engine. It takes a stream of 32-bit words, one word per cycle when `inValid` is high, and turns each command into a series of register writes. A command opens with a control word. That word holds a wrap flag, a flag that says a data trailer follows, and a 16-bit mask of write enables. One data word follows for each set enable. The data words are applied to the registers in a fixed ascending order, and a register whose enable is clear takes no word.

When the trailer flag is set, a descriptor follows the register data. The descriptor gives a data type and a word count, and the parser then forwards that many payload words on its payload output. After the last word of a command, the parser raises a one-cycle done pulse. A wrap indication travels with that pulse so the fetcher can rewind its read pointer. If a control word has either of its reserved-zero bits set, the parser raises a sticky error and ignores all input until reset.

Top module: `cmd_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low or zero: `regWrEn`, `regIdx`, `regData`, `payValid`, `payData`, `payType`, `cmdDone`, `cmdWrap` and `errFlag`.
- R2: Each write enable bit k (control word bits 15:0) that is set consumes exactly one following data word. That word appears on `regData` with `regIdx` = k. The writes of one command come out in ascending k.
- R3: A register whose enable bit is clear is skipped and consumes no word, so gaps in the mask do not shift the indices of later writes.
- R4: When control bit 28 is clear, no descriptor is expected. The command ends with its last register word, or with the control word itself if the mask is zero.
- R5: When control bit 28 is set, the word after the register data is a descriptor. Its bits 31:28 appear on `payType`, and bits 15:0 give a count N. The next N words are forwarded on `payData` with `payValid`, and none of them is a register write.
- R6: A descriptor with N = 0 ends the command at once, with no payload.
- R7: `cmdDone` pulses high for one cycle, one cycle after the last word of a command is accepted. `cmdWrap` is high in that cycle exactly when bit 31 of that command's control word was set.
- R8: A control word with bit 30 or bit 29 set makes `errFlag` high from the next cycle onward, until reset. While it is high, no write, payload or done output occurs.
- R9: Every output event appears one cycle after the word that caused it is accepted. Cycles with `inValid` low produce no output event and do not advance parsing.
- R10: Bits 27:16 of a control word have no effect on parsing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word present this cycle |
| inData | input | 32 | Command stream word |
| regWrEn | output | 1 | Register write strobe |
| regIdx | output | 4 | Index of register being written |
| regData | output | 32 | Value for register write |
| payValid | output | 1 | Payload word strobe |
| payData | output | 32 | Payload word |
| payType | output | 4 | Data type from latest descriptor |
| cmdDone | output | 1 | Command complete pulse |
| cmdWrap | output | 1 | Wrap request, valid with cmdDone |
| errFlag | output | 1 | Sticky malformed-control-word error |

## Verification
The assertions check several properties on every cycle:
- a register write and a payload word never appear in the same cycle;
- the wrap output is only high together with done;
- the error state is sticky and stays silent;
- the payload counter never sits at zero while words are still owed.

Other behaviour only the bench's scenarios can show. This covers the mapping from mask bit to register index, the skipping of clear enables, the end of a command with and without the trailer, the empty-trailer case, the one-cycle latency across idle input cycles, and the choice between the control word's own wrap bit and the latched one.

// File: rtl/cmd_parser_pkg.sv
package cmd_parser_pkg;
  localparam int WORD_W   = 32;
  localparam int REG_N    = 16;
  localparam int REG_IDX_W = $clog2(REG_N);
  localparam int CNT_W    = 16;
  localparam int TYPE_W   = 4;
  localparam int BIT_WRAP = WORD_W - 1;
  localparam int BIT_RSV1 = WORD_W - 2;
  localparam int BIT_RSV0 = WORD_W - 3;
  localparam int BIT_TRL  = WORD_W - 4;

  typedef enum logic [2:0] {
    ST_CTRL, ST_REG, ST_DESC, ST_PAY, ST_ERR
  } parseState_t;

  typedef struct packed {
    logic ldCtrl;
    logic regWr;
    logic ldDesc;
    logic payWr;
    logic done;
  } strobes_t;
endpackage

// File: rtl/cmd_parser_ctrl.sv
module cmd_parser_ctrl
  import cmd_parser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  input  logic              pendLast,
  output strobes_t          stb,
  output logic              errFlag
);
  parseState_t state, stateNext;
  logic [CNT_W-1:0] payCnt, payCntNext;
  logic trlLat, trlLatNext;

  logic ctrlBad;
  logic ctrlMaskZero;
  logic [CNT_W-1:0] descCnt;

  assign ctrlBad      = inData[BIT_RSV1] | inData[BIT_RSV0];
  assign ctrlMaskZero = (inData[REG_N-1:0] == '0);
  assign descCnt      = inData[CNT_W-1:0];

  always_comb begin
    stb        = '0;
    stateNext  = state;
    payCntNext = payCnt;
    trlLatNext = trlLat;
    unique case (state)
      ST_CTRL: if (inValid) begin
        if (ctrlBad) begin
          stateNext = ST_ERR;
        end else begin
          stb.ldCtrl = 1'b1;
          trlLatNext = inData[BIT_TRL];
          if (!ctrlMaskZero)        stateNext = ST_REG;
          else if (inData[BIT_TRL]) stateNext = ST_DESC;
          else                      stb.done  = 1'b1;
        end
      end
      ST_REG: if (inValid) begin
        stb.regWr = 1'b1;
        if (pendLast) begin
          if (trlLat) stateNext = ST_DESC;
          else begin
            stb.done  = 1'b1;
            stateNext = ST_CTRL;
          end
        end
      end
      ST_DESC: if (inValid) begin
        stb.ldDesc = 1'b1;
        if (descCnt == '0) begin
          stb.done  = 1'b1;
          stateNext = ST_CTRL;
        end else begin
          payCntNext = descCnt;
          stateNext  = ST_PAY;
        end
      end
      ST_PAY: if (inValid) begin
        stb.payWr  = 1'b1;
        payCntNext = payCnt - CNT_W'(1);
        if (payCnt == CNT_W'(1)) begin
          stb.done  = 1'b1;
          stateNext = ST_CTRL;
        end
      end
      default: stateNext = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_CTRL;
      payCnt <= '0;
      trlLat <= 1'b0;
    end else begin
      state  <= stateNext;
      payCnt <= payCntNext;
      trlLat <= trlLatNext;
    end
  end

  assign errFlag = (state == ST_ERR);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_pay_owed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAY) |-> (payCnt != '0));
endmodule

// File: rtl/cmd_parser_dp.sv
module cmd_parser_dp
  import cmd_parser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_W-1:0]    inData,
  input  strobes_t             stb,
  output logic                 pendLast,
  output logic                 regWrEn,
  output logic [REG_IDX_W-1:0] regIdx,
  output logic [WORD_W-1:0]    regData,
  output logic                 payValid,
  output logic [WORD_W-1:0]    payData,
  output logic [TYPE_W-1:0]    payType,
  output logic                 cmdDone,
  output logic                 cmdWrap
);
  logic [REG_N-1:0]     pendMask;
  logic [REG_N-1:0]     lowBit;
  logic [REG_IDX_W-1:0] lowIdx;
  logic                 wrapLat;
  logic                 wrapSel;

  assign lowBit   = pendMask & (~pendMask + REG_N'(1));
  assign pendLast = ((pendMask & (pendMask - REG_N'(1))) == '0);
  assign wrapSel  = stb.ldCtrl ? inData[BIT_WRAP] : wrapLat;

  always_comb begin
    lowIdx = '0;
    for (int k = REG_N - 1; k >= 0; k--) begin
      if (pendMask[k]) lowIdx = REG_IDX_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
      wrapLat  <= 1'b0;
      regWrEn  <= 1'b0;
      regIdx   <= '0;
      regData  <= '0;
      payValid <= 1'b0;
      payData  <= '0;
      payType  <= '0;
      cmdDone  <= 1'b0;
      cmdWrap  <= 1'b0;
    end else begin
      regWrEn  <= stb.regWr;
      payValid <= stb.payWr;
      cmdDone  <= stb.done;
      cmdWrap  <= stb.done & wrapSel;
      if (stb.ldCtrl) begin
        pendMask <= inData[REG_N-1:0];
        wrapLat  <= inData[BIT_WRAP];
      end
      if (stb.regWr) begin
        pendMask <= pendMask & ~lowBit;
        regIdx   <= lowIdx;
        regData  <= inData;
      end
      if (stb.ldDesc) payType <= inData[WORD_W-1 -: TYPE_W];
      if (stb.payWr)  payData <= inData;
    end
  end

  p_excl_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && payValid));

  p_wrap_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrap |-> cmdDone);
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_parser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inData,
  output logic        regWrEn,
  output logic [3:0]  regIdx,
  output logic [31:0] regData,
  output logic        payValid,
  output logic [31:0] payData,
  output logic [3:0]  payType,
  output logic        cmdDone,
  output logic        cmdWrap,
  output logic        errFlag
);
  strobes_t stb;
  logic     pendLast;

  cmd_parser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .pendLast(pendLast), .stb(stb), .errFlag(errFlag)
  );

  cmd_parser_dp u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .stb(stb),
    .pendLast(pendLast), .regWrEn(regWrEn), .regIdx(regIdx),
    .regData(regData), .payValid(payValid), .payData(payData),
    .payType(payType), .cmdDone(cmdDone), .cmdWrap(cmdWrap)
  );

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (!regWrEn && !payValid && !cmdDone));
endmodule

// File: tb/cmd_parser_tb.sv
module cmd_parser_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        regWrEn, payValid, cmdDone, cmdWrap, errFlag;
  logic [3:0]  regIdx, payType;
  logic [31:0] regData, payData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cmd_parser u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .regWrEn(regWrEn), .regIdx(regIdx), .regData(regData),
    .payValid(payValid), .payData(payData), .payType(payType),
    .cmdDone(cmdDone), .cmdWrap(cmdWrap), .errFlag(errFlag)
  );

  // layout: {valid, data[31:0], kind[1:0] (0 none,1 reg,2 pay), idx[3:0], done, wrap}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 32'h0000_0005, 2'd0, 4'd0,  1'b0, 1'b0}, // ctrl mask bits 0,2
    {1'b1, 32'h0000_00A1, 2'd1, 4'd0,  1'b0, 1'b0}, // R2 idx0
    {1'b0, 32'hDEAD_BEEF, 2'd0, 4'd0,  1'b0, 1'b0}, // R9 idle
    {1'b1, 32'h0000_00A2, 2'd1, 4'd2,  1'b1, 1'b0}, // R3 idx2, R4 done
    {1'b1, 32'h9FF0_8001, 2'd0, 4'd0,  1'b0, 1'b0}, // R10 junk, wrap, trailer
    {1'b1, 32'h0000_00B0, 2'd1, 4'd0,  1'b0, 1'b0},
    {1'b1, 32'h0000_00B1, 2'd1, 4'd15, 1'b0, 1'b0}, // R3 gap to 15
    {1'b1, 32'h5000_0002, 2'd0, 4'd0,  1'b0, 1'b0}, // R5 descriptor N=2
    {1'b1, 32'h0000_00C0, 2'd2, 4'd0,  1'b0, 1'b0},
    {1'b1, 32'h0000_00C1, 2'd2, 4'd0,  1'b1, 1'b1}, // R7 done with wrap
    {1'b1, 32'h8000_0000, 2'd0, 4'd0,  1'b1, 1'b1}, // R4 empty, wrap own bit
    {1'b1, 32'h1000_0000, 2'd0, 4'd0,  1'b0, 1'b0}, // trailer only
    {1'b1, 32'h3000_0000, 2'd0, 4'd0,  1'b1, 1'b0}, // R6 N=0
    {1'b1, 32'h0000_4000, 2'd0, 4'd0,  1'b0, 1'b0},
    {1'b1, 32'h0000_00E1, 2'd1, 4'd14, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkVec(input int i);
    logic [40:0] v;
    logic [1:0] kind;
    v = VEC[i];
    kind = v[7:6];
    check($sformatf("R2 R9 regWrEn v%0d", i), 32'(regWrEn), 32'(kind == 2'd1));
    check($sformatf("R5 R9 payValid v%0d", i), 32'(payValid), 32'(kind == 2'd2));
    if (kind == 2'd1) begin
      check($sformatf("R2 R3 regIdx v%0d", i), 32'(regIdx), 32'(v[5:2]));
      check($sformatf("R2 regData v%0d", i), regData, v[39:8]);
    end
    if (kind == 2'd2) check($sformatf("R5 payData v%0d", i), payData, v[39:8]);
    check($sformatf("R4 R6 R7 cmdDone v%0d", i), 32'(cmdDone), 32'(v[1]));
    check($sformatf("R7 cmdWrap v%0d", i), 32'(cmdWrap), 32'(v[0]));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 outputs idle", {regWrEn, payValid, cmdDone, cmdWrap, errFlag}, 32'd0);
    check("R1 regIdx/payType", {regIdx, payType}, 32'd0);
    check("R1 regData", regData, 32'd0);
    check("R1 payData", payData, 32'd0);

    for (int i = 0; i < NV; i++) begin
      inValid = VEC[i][40];
      inData  = VEC[i][39:8];
      @(negedge clk);
      checkVec(i);
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R5 payType latest", 32'(payType), 32'd3);
    check("R9 idle after stream", {regWrEn, payValid, cmdDone}, 32'd0);

    // R8 bit 29 error
    inValid = 1'b1; inData = 32'h2000_0001;
    @(negedge clk);
    check("R8 errFlag set bit29", 32'(errFlag), 32'd1);
    inData = 32'h0000_0000;
    @(negedge clk);
    check("R8 no done while error", 32'(cmdDone), 32'd0);
    inData = 32'h0000_0077;
    @(negedge clk);
    check("R8 no write while error", {regWrEn, payValid}, 32'd0);
    check("R8 errFlag sticky", 32'(errFlag), 32'd1);
    doReset();
    check("R1 errFlag cleared", 32'(errFlag), 32'd0);

    // R8 bit 30 error
    inValid = 1'b1; inData = 32'h4000_0000;
    @(negedge clk);
    check("R8 errFlag set bit30", 32'(errFlag), 32'd1);
    check("R8 no done for bad ctrl", 32'(cmdDone), 32'd0);
    doReset();

    // R2 full mask, ascending order
    inValid = 1'b1; inData = 32'h0000_FFFF;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      inData = 32'h100 + 32'(k);
      @(negedge clk);
      check($sformatf("R2 full mask idx %0d", k), 32'(regIdx), 32'(k));
      check($sformatf("R4 done at idx %0d", k), 32'(cmdDone), 32'(k == 15));
    end
    inValid = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule